// File: doc/BRIEF.md
# Fractional Microsecond Timebase

This block turns a fast reference clock into a steady one-microsecond tick and counts those ticks in a free-running up-counter. The ratio between the reference and the tick is a pair of small integers, a multiplier and a divisor, rather than a plain integer divider. Reference rates that are not whole megahertz therefore still give an exact average rate of 1 MHz. For example, 19.2 MHz with a ratio of 5/96 gives five ticks in every 96 reference cycles.

A small register port lets a bus master read the count, set the ratio and pause the count. A ratio accumulator adds the multiplier on every reference cycle. When the sum reaches the divisor, it subtracts the divisor and emits one tick. The tick is also available as a one-cycle pulse for local consumers. The reset input is asynchronous and active low. The block synchronises its release to the clock.

Top module: `usec_timebase`

## Requirements
- R1: While `rst_n` is low, and until the second rising clock edge after it goes high, the block holds its reset state: count 0, ratio register 0x0000000B (multiplier 1, divisor 12), hold bit 0, no tick. Accumulation begins on the third edge after release.
- R2: With multiplier M and divisor D, the block adds M to the accumulator each active cycle. When the sum is D or more, it subtracts D and emits a tick, so ratio 0x000B gives exactly one tick every 12 cycles. `usec_tick` is high for the one cycle in which the count shows its new value.
- R3: Fractional ratios are exact on average. Ratio 0x045F gives exactly 50 ticks in 960 cycles after the accumulator is cleared.
- R4: The ratio register is at offset 0x14. Bits [15:8] hold M-1 and bits [7:0] hold D-1. Bits [31:16] are ignored on write and read as zero. Software must keep M ≤ D.
- R5: A write to the ratio register clears the accumulator and suppresses any tick on that edge. The first tick under the new ratio follows from a zero accumulator, even when the write lands on the edge where a tick was due.
- R6: Bit 0 at offset 0x4C is the hold bit. While it is set, the count keeps its value, but the accumulator and `usec_tick` keep running. The hold bit in force before a write applies to the edge of that write.
- R7: The count is read at offset 0x10, zero-extended to the bus width. Writes to that offset are ignored. The count wraps from its all-ones value to zero.
- R8: Reads of any other offset, and any read with `bus_sel` low, return zero. Writes to any other offset change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, qualified by `bus_sel` |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| usec_tick | output | 1 | One-cycle pulse per microsecond tick |

## Verification
The tick can coincide with either kind of register write. A ratio write landing on a due tick must clear the accumulator and swallow that tick. A hold write landing on a tick must let the old hold value decide whether that tick counts. The bench provokes the first case by rewriting ratio 0x000B exactly twelve cycles after a previous write. The second case arises while the hold bit is toggled under running ticks. A behavioural model applies the same ordering on every clock and compares the read data and the tick pulse.

// File: rtl/ustb_pkg.sv
package ustb_pkg;
  localparam int RATIO_FW = 8;

  localparam logic [7:0] OFS_COUNT = 8'h10;
  localparam logic [7:0] OFS_RATIO = 8'h14;
  localparam logic [7:0] OFS_HOLD  = 8'h4C;

  typedef struct packed {
    logic [RATIO_FW-1:0] mul_m1;
    logic [RATIO_FW-1:0] div_m1;
  } ratio_t;

  localparam ratio_t RATIO_RST = '{mul_m1: 8'h00, div_m1: 8'h0B};
endpackage

// File: rtl/ustb_ratio_acc.sv
module ustb_ratio_acc #(
  parameter int FW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic [FW-1:0] mul_m1_i,
  input  logic [FW-1:0] div_m1_i,
  output logic          wrap_o,
  output logic          tick_o
);
  localparam int AW = FW + 1;

  logic [AW-1:0] acc_q, acc_d, mul, dvs, sum;
  logic          tick_d;

  assign mul = {1'b0, mul_m1_i} + AW'(1);
  assign dvs = {1'b0, div_m1_i} + AW'(1);
  assign sum = acc_q + mul;

  always_comb begin
    wrap_o = (sum >= dvs) && !clr_i;
    tick_d = wrap_o;
    if (clr_i)       acc_d = '0;
    else if (wrap_o) acc_d = sum - dvs;
    else             acc_d = sum;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      tick_o <= 1'b0;
    end else begin
      acc_q  <= acc_d;
      tick_o <= tick_d;
    end
  end

  // R5
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (acc_q == '0) && !tick_o);

  // R2
  acc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q < dvs);
endmodule

// File: rtl/ustb_counter.sv
module ustb_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step_i,
  input  logic         hold_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  assign cnt_en = step_i && !hold_i;
  assign cnt_o  = cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_en) cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R6
  hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> $stable(cnt_q));

  // R7
  step_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !hold_i) |=> (cnt_q == $past(cnt_q) + W'(1)));

  // R2
  idle_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step_i |=> $stable(cnt_q));
endmodule

// File: rtl/ustb_regs.sv
module ustb_regs
  import ustb_pkg::*;
#(
  parameter int CW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_i,
  input  logic          wr_i,
  input  logic [7:0]    addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [CW-1:0] cnt_i,
  output ratio_t        ratio_o,
  output logic          hold_o,
  output logic          clr_o,
  output logic [DW-1:0] rdata_o
);
  ratio_t ratio_q, ratio_d;
  logic   hold_q, hold_d;
  logic   wr_ratio, wr_hold;
  logic   wdata_unused;

  assign wdata_unused = ^wdata_i[DW-1:16];

  assign wr_ratio = sel_i && wr_i && (addr_i == OFS_RATIO);
  assign wr_hold  = sel_i && wr_i && (addr_i == OFS_HOLD);

  always_comb begin
    ratio_d = ratio_q;
    hold_d  = hold_q;
    if (wr_ratio) ratio_d = ratio_t'(wdata_i[15:0]);
    if (wr_hold)  hold_d  = wdata_i[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ratio_q <= RATIO_RST;
      hold_q  <= 1'b0;
    end else begin
      ratio_q <= ratio_d;
      hold_q  <= hold_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (sel_i) begin
      case (addr_i)
        OFS_COUNT: rdata_o = DW'(cnt_i);
        OFS_RATIO: rdata_o = DW'(ratio_q);
        OFS_HOLD:  rdata_o = DW'(hold_q);
        default:   rdata_o = '0;
      endcase
    end
  end

  assign ratio_o = ratio_q;
  assign hold_o  = hold_q;
  assign clr_o   = wr_ratio;

  // R8
  quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel_i && wr_i) |=> $stable(ratio_q) && $stable(hold_q));
endmodule

// File: rtl/usec_timebase.sv
module usec_timebase
  import ustb_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [7:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              usec_tick
);
  logic       rst_meta, rst_sync;
  ratio_t     ratio;
  logic       hold, clr, wrap;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  ustb_regs #(.CW(CNT_W), .DW(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_sync),
    .sel_i(bus_sel), .wr_i(bus_wr), .addr_i(bus_addr), .wdata_i(bus_wdata),
    .cnt_i(cnt), .ratio_o(ratio), .hold_o(hold), .clr_o(clr),
    .rdata_o(bus_rdata)
  );

  ustb_ratio_acc #(.FW(RATIO_FW)) u_acc (
    .clk(clk), .rst_n(rst_sync), .clr_i(clr),
    .mul_m1_i(ratio.mul_m1), .div_m1_i(ratio.div_m1),
    .wrap_o(wrap), .tick_o(usec_tick)
  );

  ustb_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_sync), .step_i(wrap), .hold_i(hold),
    .cnt_o(cnt)
  );

  // R1
  rst_hold_chk: assert property (@(posedge clk)
    !rst_sync |-> !usec_tick);
endmodule

// File: tb/usec_timebase_test.sv
module usec_timebase_test;
  localparam int TB_CW = 10;
  localparam int CMOD  = 1 << TB_CW;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic        usec_tick;

  int total = 0;
  int bad = 0;
  string cur_req = "R1";

  int m_acc = 0, m_cnt = 0, m_mul = 0, m_div = 11, m_hold = 0, m_tick = 0, m_rel = 0;
  int tick_seen = 0;
  int prev_rd = -1;
  bit wrap_seen = 0;

  always #4 clk = ~clk;

  usec_timebase #(.CNT_W(TB_CW), .DATA_W(32)) uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .usec_tick(usec_tick)
  );

  // behavioural reference, one step per clock
  always @(posedge clk) begin
    if (!rst_n) begin
      m_acc = 0; m_cnt = 0; m_mul = 0; m_div = 11; m_hold = 0; m_tick = 0; m_rel = 0;
    end else if (m_rel < 2) begin
      m_rel = m_rel + 1;
    end else begin
      if (bus_sel && bus_wr && bus_addr == 8'h14) begin
        m_mul = int'(bus_wdata[15:8]); m_div = int'(bus_wdata[7:0]);
        m_acc = 0; m_tick = 0;
      end else if (m_acc + m_mul + 1 >= m_div + 1) begin
        m_acc = m_acc + m_mul - m_div;
        m_tick = 1;
        if (m_hold == 0) m_cnt = (m_cnt + 1) % CMOD;
      end else begin
        m_acc = m_acc + m_mul + 1;
        m_tick = 0;
      end
      if (bus_sel && bus_wr && bus_addr == 8'h4C) m_hold = int'(bus_wdata[0]);
    end
  end

  function automatic int model_rd();
    if (!bus_sel) return 0;
    case (bus_addr)
      8'h10: return m_cnt;
      8'h14: return (m_mul << 8) | m_div;
      8'h4C: return m_hold;
      default: return 0;
    endcase
  endfunction

  task automatic chk(string req, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, got, exp);
    end
  endtask

  task automatic cyc(logic s, logic w, logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    chk({cur_req, " rdata"}, int'(bus_rdata), model_rd());
    chk({cur_req, " tick"}, int'(usec_tick), m_tick);
    if (usec_tick === 1'b1) tick_seen++;
    if (bus_sel && bus_addr == 8'h10) begin
      if (prev_rd == CMOD - 1 && bus_rdata == 32'd0) wrap_seen = 1;
      prev_rd = int'(bus_rdata);
    end
    bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = d;
  endtask

  task automatic idle(int n, logic [7:0] a);
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, a, 32'h0);
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    cyc(1'b1, 1'b1, a, d);
  endtask

  task automatic rd(logic [7:0] a, int exp, string req);
    cyc(1'b1, 1'b0, a, 32'h0);
    #1;
    chk(req, int'(bus_rdata), exp);
  endtask

  initial begin
    int v;
    // R1: reset state
    for (int i = 0; i < 4; i++) cyc(1'b0, 1'b0, 8'h00, 32'h0);
    rst_n = 1'b1;
    rd(8'h14, 32'h0000000B, "R1 ratio reset");
    rd(8'h4C, 0, "R1 hold reset");
    rd(8'h10, 0, "R1 count reset");

    // R2: integer ratio 1/12
    cur_req = "R2";
    wr(8'h14, 32'h0000000B);
    tick_seen = 0;
    idle(241, 8'h10);
    chk("R2 ticks in 240 cycles", tick_seen, 20);

    // R3: fractional ratio 5/96
    cur_req = "R3";
    wr(8'h14, 32'h0000045F);
    tick_seen = 0;
    idle(961, 8'h10);
    chk("R3 ticks in 960 cycles", tick_seen, 50);

    // R5: ratio write lands on the edge of a due tick
    cur_req = "R5";
    wr(8'h14, 32'h0000000B);
    tick_seen = 0;
    idle(11, 8'h10);
    wr(8'h14, 32'h0000000B);
    idle(12, 8'h10);
    chk("R5 tick swallowed by write", tick_seen, 0);
    idle(1, 8'h10);
    chk("R5 first tick after clear", tick_seen, 1);

    // R6: hold bit
    cur_req = "R6";
    wr(8'h4C, 32'h1);
    cyc(1'b1, 1'b0, 8'h10, 32'h0);
    #1 v = int'(bus_rdata);
    tick_seen = 0;
    idle(100, 8'h10);
    rd(8'h10, v, "R6 count held");
    chk("R6 ticks continue", int'(tick_seen > 0), 1);
    rd(8'h4C, 1, "R6 hold readback");
    wr(8'h4C, 32'h0);
    idle(30, 8'h10);
    cyc(1'b1, 1'b0, 8'h10, 32'h0);
    #1 chk("R6 count resumes", int'(int'(bus_rdata) != v), 1);

    // R4: field layout and upper bits
    cur_req = "R4";
    wr(8'h14, 32'hABCD045F);
    rd(8'h14, 32'h0000045F, "R4 ratio readback");

    // R8: unmapped and deselected accesses
    cur_req = "R8";
    wr(8'h20, 32'hFFFFFFFF);
    rd(8'h20, 0, "R8 unmapped read");
    rd(8'h14, 32'h0000045F, "R8 ratio untouched");
    cyc(1'b0, 1'b0, 8'h14, 32'h0);
    #1 chk("R8 deselected read", int'(bus_rdata), 0);

    // R7: count write ignored, wrap
    cur_req = "R7";
    wr(8'h10, 32'h00000155);
    wr(8'h14, 32'h00000000);
    prev_rd = -1;
    idle(1100, 8'h10);
    chk("R7 count wrapped", int'(wrap_seen), 1);

    // R1: reset again mid-run
    cur_req = "R1";
    rst_n = 1'b0;
    idle(3, 8'h10);
    rd(8'h14, 32'h0000000B, "R1 ratio after reset");
    rd(8'h10, 0, "R1 count after reset");
    rst_n = 1'b1;
    idle(30, 8'h10);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog all actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule